// File: doc/BRIEF.md
# Valid-Aware Column Thermometer Decoder

This block drives the cell enables of one row of a segmented current-steering array. The row holds more cells than full scale needs, and each cell carries a usability bit. A 4-bit column code asks for N cells. The decoder switches on the first N usable cells, counting up from index 0, and passes over any cell whose usability bit is clear. The result is a thermometer fill that closes up around the holes in the row.

The decoder is purely combinational. Its outputs follow the code and the mask within the same cycle, and it has no clock and no reset. The mask comes from storage that sits outside this block. No data stream enters or leaves the block, so there is no valid/ready handshake and there is no back-pressure. Every pin is a plain level. If the row holds fewer usable cells than the code asks for, the decoder enables every usable cell and raises a shortage flag.

Cell i corresponds to bit i of both the mask and the enable vector. A mask bit of 1 means the cell is usable. The defaults are a 4-bit code and 2 spare cells, which gives 18 cells in the row.

Top module: `valid_skip_col_decoder`

## Requirements
- R1: When `col_code_i` is 0, `cell_en_o` is all zeros, whatever the mask.
- R2: A cell whose `valid_mask_i` bit is 0 never has its `cell_en_o` bit set to 1.
- R3: When the mask holds at least N ones, where N is the unsigned value of `col_code_i`, exactly N bits of `cell_en_o` are 1.
- R4: The enabled cells are the lowest-indexed usable cells. No usable cell that is off sits at a lower index than an enabled cell.
- R5: When the mask holds fewer than N ones, `cell_en_o` equals `valid_mask_i` and `short_o` is 1.
- R6: When the mask holds N or more ones, `short_o` is 0.
- R7: With an all-ones mask, code N enables cells 0 to N-1 and nothing else. The two top spare cells (bits 16 and 17) then stay off for every code.
- R8: The outputs depend only on the present inputs. They are settled within one bench step of an input change, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| col_code_i | input | 4 | Number of cells requested, unsigned |
| valid_mask_i | input | 18 | Per-cell usability bits; bit i = cell i, 1 = usable |
| cell_en_o | output | 18 | Per-cell enable; bit i = cell i |
| short_o | output | 1 | High when the usable cells are fewer than the code |

## Verification
The bench aims at holes that sit just below the boundary of the fill. A decoder that counted raw indices instead of usable cells would turn on an unusable cell, or would stop one cell short. Masks with exactly N, N-1 and zero usable cells probe the shortage edge, where an off-by-one comparison would set the flag wrongly or enable an extra cell. Holes at the very top and very bottom of the row, together with the all-usable row, expose a fill that runs into the spare cells too early. Code 0 catches a decoder that treats zero as a full row.

// File: rtl/coldec_pkg.sv
package coldec_pkg;
  localparam int CODE_W_DEF = 4;
  localparam int SPARE_DEF  = 2;
endpackage

// File: rtl/coldec_prefix.sv
module coldec_prefix #(
  parameter int CELLS = 18,
  parameter int CNT_W = 5
) (
  input  logic [CELLS-1:0]            valid_i,
  output logic [CELLS:0][CNT_W-1:0]   run_o
);
  // run_o[i] = number of usable cells strictly below index i
  assign run_o[0] = '0;
  for (genvar i = 0; i < CELLS; i++) begin : g_run
    assign run_o[i+1] = run_o[i] + CNT_W'(valid_i[i]);
  end
endmodule

// File: rtl/coldec_gate.sv
module coldec_gate #(
  parameter int CELLS  = 18,
  parameter int CNT_W  = 5,
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0]            code_i,
  input  logic [CELLS-1:0]             valid_i,
  input  logic [CELLS-1:0][CNT_W-1:0]  run_i,
  output logic [CELLS-1:0]             en_o
);
  logic [CNT_W-1:0] want;
  assign want = CNT_W'(code_i);

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign en_o[i] = valid_i[i] && (run_i[i] < want);
  end

  always_comb begin
    assert_skip_unusable_R2: assert ((en_o & ~valid_i) == '0)
      else $error("R2: unusable cell enabled");
    assert_zero_code_R1: assert (code_i != '0 || en_o == '0)
      else $error("R1: enable with zero code");
  end
endmodule

// File: rtl/coldec_short.sv
module coldec_short #(
  parameter int CNT_W  = 5,
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  total_i,
  output logic              short_o
);
  assign short_o = total_i < CNT_W'(code_i);
endmodule

// File: rtl/valid_skip_col_decoder.sv
module valid_skip_col_decoder
  import coldec_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int SPARE  = SPARE_DEF
) (
  input  logic [CODE_W-1:0]                 col_code_i,
  input  logic [(1<<CODE_W)+SPARE-1:0]      valid_mask_i,
  output logic [(1<<CODE_W)+SPARE-1:0]      cell_en_o,
  output logic                              short_o
);
  localparam int NEED  = 1 << CODE_W;
  localparam int CELLS = NEED + SPARE;
  localparam int CNT_W = $clog2(CELLS + 1);

  logic [CELLS:0][CNT_W-1:0] run;

  coldec_prefix #(.CELLS(CELLS), .CNT_W(CNT_W)) u_prefix (
    .valid_i (valid_mask_i),
    .run_o   (run)
  );

  coldec_gate #(.CELLS(CELLS), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_gate (
    .code_i  (col_code_i),
    .valid_i (valid_mask_i),
    .run_i   (run[CELLS-1:0]),
    .en_o    (cell_en_o)
  );

  coldec_short #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_short (
    .code_i  (col_code_i),
    .total_i (run[CELLS]),
    .short_o (short_o)
  );

  always_comb begin
    assert_count_R3: assert (short_o ||
        $countones(cell_en_o) == int'(col_code_i))
      else $error("R3: enabled count differs from code");
    assert_short_all_R5: assert (!short_o || cell_en_o == valid_mask_i)
      else $error("R5: shortage without full enable");
    assert_flag_R6: assert (short_o ==
        ($countones(valid_mask_i) < int'(col_code_i)))
      else $error("R6: shortage flag mismatch");
    for (int i = 0; i < CELLS; i++) begin
      for (int j = i + 1; j < CELLS; j++) begin
        assert_lowest_first_R4: assert (!(valid_mask_i[i] && !cell_en_o[i]
                                          && cell_en_o[j]))
          else $error("R4: usable cell %0d skipped below %0d", i, j);
      end
    end
  end
endmodule

// File: tb/valid_skip_col_decoder_tb_top.sv
module valid_skip_col_decoder_tb_top;
  localparam int CELLS = 18;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst;
  logic [3:0]       code;
  logic [CELLS-1:0] mask;
  logic [CELLS-1:0] en;
  logic             shrt;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  valid_skip_col_decoder dut_i (
    .col_code_i   (code),
    .valid_mask_i (mask),
    .cell_en_o    (en),
    .short_o      (shrt)
  );

  function automatic logic [CELLS-1:0] model_en(logic [3:0] c, logic [CELLS-1:0] m);
    logic [CELLS-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < CELLS; i++)
      if (m[i] && k < int'(c)) begin r[i] = 1'b1; k++; end
    return r;
  endfunction

  function automatic int ones(logic [CELLS-1:0] m);
    int n = 0;
    for (int i = 0; i < CELLS; i++) n += int'(m[i]);
    return n;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s code=%0d mask=%h actual=%h expected=%h",
               tag, code, mask, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] c, logic [CELLS-1:0] m);
    int nv;
    @(negedge clk);
    code = c; mask = m;
    #1; // R8: no clock edge between input change and sampling
    nv = ones(m);
    chk("R2 subset", 32'(en & ~m), 32'd0);
    chk("R4 fill", 32'(en), 32'(model_en(c, m)));
    if (nv >= int'(c)) begin
      chk("R3 count", ones(en), 32'(c));
      chk("R6 flag", 32'(shrt), 32'd0);
    end else begin
      chk("R5 all", 32'(en), 32'(m));
      chk("R5 flag", 32'(shrt), 32'd1);
    end
    if (c == 4'd0) chk("R1 zero", 32'(en), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; code = '0; mask = '1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    chk("R1 initial en", 32'(en), 32'd0);
    chk("R6 initial flag", 32'(shrt), 32'd0);
    // R7: all usable -> plain thermometer, spares 16/17 off
    for (int c = 0; c < 16; c++) begin
      apply(4'(c), '1);
      chk("R7 therm", 32'(en), (32'd1 << c) - 32'd1);
      chk("R7 spares", 32'(en[17:16]), 32'd0);
    end
    apply(4'd15, '0);
    apply(4'd0, '0);
    apply(4'd15, 18'h3FFFE);
    apply(4'd15, 18'h1FFFF);
    apply(4'd15, 18'h0FFFF);
    apply(4'd15, 18'h07FFF);
    apply(4'd15, 18'h03FFF);
    apply(4'd15, 18'h3FFF0);
    apply(4'd8, 18'h2AAAA);
    apply(4'd9, 18'h15555);
    apply(4'd1, 18'h20000);
    apply(4'd2, 18'h20000);
    void'($urandom(32'd4242));
    for (int n = 0; n < 400; n++) begin
      logic [CELLS-1:0] m;
      if (n % 2 == 0) m = CELLS'(~($urandom & $urandom & $urandom));
      else            m = CELLS'($urandom);
      apply(4'($urandom), m);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule